// File: doc/BRIEF.md
# Byte-Masked Remote Word Writer

This block turns one 64-bit command word into a single 32-bit store on a target register space, with selected bytes of the existing word protected. A four-bit protect field in the command names the bytes whose current contents must survive. When any of those bits is set, the block first fetches the target word, then combines it with the new data and stores the result. When none is set, it skips the fetch and stores the new data as a whole.

Two command kinds share the path. A mailbox command lands in a small, word-aligned window above a fixed base. A free-address command carries its target address directly. Each command also names a destination core. That number is presented alongside the access so that an outer fabric can steer it. A number at or beyond the configured core count makes the block discard the command and raise a one-cycle drop pulse. Commands that were not issued as 64-bit writes are consumed and have no effect.

Top module: `rww_top`

## Requirements
- R1: The protect field is command bits 30:27, and bit i covers byte i (bits 8i+7:8i). The stored word takes byte i from the fetched word where protect bit i is 1, and from command bits 32+8i+7:32+8i where it is 0.
- R2: When the protect field is nonzero, exactly one read (`m_we`=0) is issued to the target address before the write. The write is issued only after that read is acknowledged.
- R3: When the protect field is zero, no read is issued, and the single write carries command bits 63:32 unchanged.
- R4: With `cmd_kind`=0 (mailbox), the target address is 0x1020 plus (command AND 0x1C).
- R5: With `cmd_kind`=1 (free address), the target address is command bits 15:0.
- R6: `tgt_core` shows command bits 25:16 of the command in progress for as long as its accesses last.
- R7: A command whose bits 25:16 are at or above `MAX_CORES` (default 64) causes no access. Instead, `drop_pulse` is high for exactly the one cycle after acceptance.
- R8: A command accepted with `cmd_is64`=0 causes no access and no drop pulse.
- R9: `cmd_ready` is low from the cycle after an access-causing acceptance until the write acknowledge. A request holds its address, direction and data stable until `m_ack`.
- R10: After reset, `cmd_ready` is 1, and `m_req` and `drop_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command taken on this edge if valid |
| cmd_kind | input | 1 | 0 mailbox, 1 free address |
| cmd_is64 | input | 1 | Command arrived as a 64-bit write |
| cmd_word | input | 64 | Command word |
| m_req | output | 1 | Target access request, held until acknowledge |
| m_we | output | 1 | 1 write, 0 read |
| m_addr | output | ADDR_W | Target address |
| m_wdata | output | 32 | Merged write data |
| m_rdata | input | 32 | Read data, valid with m_ack on a read |
| m_ack | input | 1 | Access complete |
| tgt_core | output | CORE_W | Destination core of the command in progress |
| drop_pulse | output | 1 | One-cycle pulse for an out-of-range core |

## Verification
An accepted command raises `m_req` on the first edge after acceptance. A drop shows on `drop_pulse` in that same cycle. The read, if any, completes on the edge that samples `m_ack`, and the write request follows on the very next cycle. `cmd_ready` returns on the edge that samples the write acknowledge. The bench drives inputs and samples all outputs on the falling edge. It records each access at the falling edge where its model raises `m_ack`, and it compares results only once `cmd_ready` has returned, so every counted read, write and drop is already settled.

// File: rtl/rww_pkg.sv
// Package: shared state and command-kind encodings for the remote word writer.
// Assumes: command field positions are fixed by the command format.
package rww_pkg;
    localparam int CMD_W     = 64;
    localparam int WORD_W    = 32;
    localparam int LANES     = WORD_W / 8;
    localparam int KEEP_LSB  = 27;
    localparam int CORE_LSB  = 16;
    localparam int DATA_LSB  = 32;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } rww_state_e;

    typedef enum logic {
        KIND_MAIL = 1'b0,
        KIND_ANY  = 1'b1
    } rww_kind_e;
endpackage

// File: rtl/rww_decode.sv
// Module: pulls the protect mask, data, core number and address out of a command.
// Assumes: purely combinational; the caller registers what it needs.
module rww_decode
    import rww_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter int              CORE_W    = 10,
    parameter int              MAX_CORES = 64,
    parameter logic [15:0]     MBOX_BASE = 16'h1020
) (
    input  logic [CMD_W-1:0]   cmd,
    input  logic               kind,
    output logic [ADDR_W-1:0]  addr,
    output logic [WORD_W-1:0]  new_word,
    output logic [LANES-1:0]   keep,
    output logic [CORE_W-1:0]  core,
    output logic               core_ok
);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(MBOX_BASE);

    // Field extraction from fixed positions.
    always_comb begin
        new_word = cmd[DATA_LSB +: WORD_W];
        keep     = cmd[KEEP_LSB +: LANES];
        core     = cmd[CORE_LSB +: CORE_W];
        core_ok  = (32'(core) < MAX_CORES);
    end

    // Address generation per command kind.
    always_comb begin
        if (kind == KIND_ANY)
            addr = ADDR_W'(cmd[15:0]);
        else
            addr = BASE_A + ADDR_W'({cmd[4:2], 2'b00});
    end
endmodule

// File: rtl/rww_merge.sv
// Module: per-byte select between the fetched word and the new word.
// Assumes: a set keep bit protects the matching byte of the old word.
module rww_merge
    import rww_pkg::*;
(
    input  logic [WORD_W-1:0] old_word,
    input  logic [WORD_W-1:0] new_word,
    input  logic [LANES-1:0]  keep,
    output logic [WORD_W-1:0] merged
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // One byte lane mux.
        assign merged[8*g +: 8] = keep[g] ? old_word[8*g +: 8] : new_word[8*g +: 8];
    end
endmodule

// File: rtl/rww_seq.sv
// Module: control sequence IDLE -> (READ) -> WRITE -> IDLE.
// Assumes: target holds nothing back once m_ack is seen; one access at a time.
module rww_seq
    import rww_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  logic cmd_is64,
    input  logic core_ok,
    input  logic keep_any,
    input  logic m_ack,
    output logic cmd_ready,
    output logic load_cmd,
    output logic load_old,
    output logic m_req,
    output logic m_we,
    output logic drop_pulse
);
    rww_state_e state;
    logic       accept;

    // Handshake and load strobes.
    always_comb begin
        cmd_ready = (state == ST_IDLE);
        accept    = cmd_valid && cmd_ready;
        load_cmd  = accept && cmd_is64 && core_ok;
        load_old  = (state == ST_READ) && m_ack;
        m_req     = (state != ST_IDLE);
        m_we      = (state == ST_WRITE);
    end

    // State register and drop pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            drop_pulse <= 1'b0;
        end else begin
            drop_pulse <= accept && cmd_is64 && !core_ok;
            case (state)
                ST_IDLE:  if (load_cmd) state <= keep_any ? ST_READ : ST_WRITE;
                ST_READ:  if (m_ack) state <= ST_WRITE;
                ST_WRITE: if (m_ack) state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // R9: an unanswered request stays up with the same direction.
    p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        m_req && !m_ack |=> m_req && $stable(m_we));
    // R9: idle means no request on the target side.
    p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> !m_req);
    // R2: a protected command starts with a read.
    p_read_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_cmd && keep_any |=> m_req && !m_we);
    // R3: an unprotected command goes straight to the write.
    p_no_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_cmd && !keep_any |=> m_req && m_we);
    // R7: a drop never coincides with an access.
    p_drop_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        drop_pulse |-> !m_req);
endmodule

// File: rtl/rww_top.sv
// Module: byte-masked remote word writer top; latches a command and runs
// the optional read, the merge and the write toward the target space.
// Assumes: one command in flight; target answers each request with m_ack.
module rww_top
    import rww_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          CORE_W    = 10,
    parameter int          MAX_CORES = 64,
    parameter logic [15:0] MBOX_BASE = 16'h1020
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic               cmd_kind,
    input  logic               cmd_is64,
    input  logic [63:0]        cmd_word,
    output logic               m_req,
    output logic               m_we,
    output logic [ADDR_W-1:0]  m_addr,
    output logic [31:0]        m_wdata,
    input  logic [31:0]        m_rdata,
    input  logic               m_ack,
    output logic [CORE_W-1:0]  tgt_core,
    output logic               drop_pulse
);
    logic [ADDR_W-1:0] d_addr;
    logic [WORD_W-1:0] d_new;
    logic [LANES-1:0]  d_keep;
    logic [CORE_W-1:0] d_core;
    logic              d_core_ok;
    logic              load_cmd, load_old;

    logic [ADDR_W-1:0] r_addr;
    logic [WORD_W-1:0] r_new, r_old;
    logic [LANES-1:0]  r_keep;
    logic [CORE_W-1:0] r_core;

    rww_decode #(
        .ADDR_W(ADDR_W), .CORE_W(CORE_W),
        .MAX_CORES(MAX_CORES), .MBOX_BASE(MBOX_BASE)
    ) u_decode (
        .cmd(cmd_word), .kind(cmd_kind), .addr(d_addr), .new_word(d_new),
        .keep(d_keep), .core(d_core), .core_ok(d_core_ok)
    );

    rww_seq u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_is64(cmd_is64),
        .core_ok(d_core_ok), .keep_any(|d_keep), .m_ack(m_ack),
        .cmd_ready(cmd_ready), .load_cmd(load_cmd), .load_old(load_old),
        .m_req(m_req), .m_we(m_we), .drop_pulse(drop_pulse)
    );

    rww_merge u_merge (
        .old_word(r_old), .new_word(r_new), .keep(r_keep), .merged(m_wdata)
    );

    // Command payload registers, loaded on an access-causing acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_addr <= '0;
            r_new  <= '0;
            r_keep <= '0;
            r_core <= '0;
        end else if (load_cmd) begin
            r_addr <= d_addr;
            r_new  <= d_new;
            r_keep <= d_keep;
            r_core <= d_core;
        end
    end

    // Fetched word register, loaded when the read is acknowledged.
    always_ff @(posedge clk) begin
        if (!rst_n)        r_old <= '0;
        else if (load_old) r_old <= m_rdata;
    end

    assign m_addr   = r_addr;
    assign tgt_core = r_core;

    // R9: address and data stay put while a request waits.
    p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        m_req && !m_ack |=> $stable(m_addr) && $stable(m_wdata));
    // R7: no access ever carries an out-of-range core.
    p_core_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        m_req |-> 32'(tgt_core) < MAX_CORES);
    // R6: the core number does not move during an access.
    p_core_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        m_req && !m_ack |=> $stable(tgt_core));
endmodule

// File: tb/tb_rww_top.sv
module tb_rww_top;
    localparam int CLK_PERIOD = 10;
    localparam int MAXC       = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        cmd_kind = 1'b0;
    logic        cmd_is64 = 1'b1;
    logic [63:0] cmd_word = '0;
    logic        m_req, m_we;
    logic [15:0] m_addr;
    logic [31:0] m_wdata;
    logic [31:0] m_rdata = '0;
    logic        m_ack = 1'b0;
    logic [9:0]  tgt_core;
    logic        drop_pulse;

    int checks = 0, errors = 0;
    int rd_cnt = 0, wr_cnt = 0, drop_cnt = 0, lat_left = 0;
    bit rd_before_wr = 0;
    logic [15:0] rd_addr, wr_addr;
    logic [31:0] wr_data;
    logic [9:0]  wr_core;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rww_top #(.MAX_CORES(MAXC)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_kind(cmd_kind), .cmd_is64(cmd_is64), .cmd_word(cmd_word),
        .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_rdata(m_rdata), .m_ack(m_ack), .tgt_core(tgt_core),
        .drop_pulse(drop_pulse)
    );

    function automatic logic [31:0] old_of(input logic [15:0] a);
        return {a, ~a} ^ 32'hA5C3_0F96;
    endfunction

    function automatic logic [31:0] exp_merge(input logic [31:0] o, input logic [31:0] n,
                                              input logic [3:0] k);
        logic [31:0] r;
        for (int i = 0; i < 4; i++) r[8*i +: 8] = k[i] ? o[8*i +: 8] : n[8*i +: 8];
        return r;
    endfunction

    function automatic logic [15:0] exp_addr(input logic kind, input logic [63:0] w);
        return kind ? w[15:0] : 16'h1020 + {11'd0, w[4:2], 2'b00};
    endfunction

    // Target model: random latency, one-cycle acknowledge, records accesses.
    always @(negedge clk) begin
        if (m_ack) m_ack = 1'b0;
        else if (rst_n && m_req) begin
            if (lat_left > 0) lat_left--;
            else begin
                m_ack = 1'b1;
                if (m_we) begin
                    wr_cnt++; wr_addr = m_addr; wr_data = m_wdata; wr_core = tgt_core;
                end else begin
                    rd_cnt++; rd_addr = m_addr; m_rdata = old_of(m_addr);
                    rd_before_wr = 1;
                end
                lat_left = $urandom % 3;
            end
        end
        if (drop_pulse) drop_cnt++;
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic run_cmd(input logic kind, input logic is64, input logic [63:0] w);
        int r0, w0, d0;
        logic [3:0] k;
        logic [9:0] c;
        logic [15:0] a;
        bit go;
        r0 = rd_cnt; w0 = wr_cnt; d0 = drop_cnt; rd_before_wr = 0;
        k = w[30:27]; c = w[25:16]; a = exp_addr(kind, w);
        go = is64 && (int'(c) < MAXC);
        @(negedge clk);
        cmd_valid = 1; cmd_kind = kind; cmd_is64 = is64; cmd_word = w;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 0;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        if (!go) begin
            check(wr_cnt == w0 && rd_cnt == r0, is64 ? "R7 no access" : "R8 no access",
                  64'(wr_cnt - w0 + rd_cnt - r0), 0);
            check(drop_cnt - d0 == (is64 ? 1 : 0), is64 ? "R7 drop pulse" : "R8 no drop",
                  64'(drop_cnt - d0), is64 ? 1 : 0);
        end else begin
            check(wr_cnt - w0 == 1, "R9 one write", 64'(wr_cnt - w0), 1);
            check(drop_cnt == d0, "R7 no drop in range", 64'(drop_cnt - d0), 0);
            check(wr_addr == a, kind ? "R5 address" : "R4 address", 64'(wr_addr), 64'(a));
            check(wr_core == c, "R6 core", 64'(wr_core), 64'(c));
            if (k != 0) begin
                check(rd_cnt - r0 == 1 && rd_before_wr, "R2 one read",
                      64'(rd_cnt - r0), 1);
                check(rd_addr == a, "R2 read address", 64'(rd_addr), 64'(a));
                check(wr_data == exp_merge(old_of(a), w[63:32], k), "R1 merge",
                      64'(wr_data), 64'(exp_merge(old_of(a), w[63:32], k)));
            end else begin
                check(rd_cnt == r0, "R3 no read", 64'(rd_cnt - r0), 0);
                check(wr_data == w[63:32], "R3 full data", 64'(wr_data), w[63:32]);
            end
        end
    endtask

    function automatic logic [63:0] mk(input logic [31:0] d, input logic [3:0] k,
                                       input logic [9:0] c, input logic [15:0] lo);
        return {d, 1'b0, k, 1'b0, c, lo};
    endfunction

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(cmd_ready == 1, "R10 ready", 64'(cmd_ready), 1);
        check(m_req == 0, "R10 no req", 64'(m_req), 0);
        check(drop_pulse == 0, "R10 no drop", 64'(drop_pulse), 0);
        // Directed corners.
        run_cmd(0, 1, mk(32'hDEADBEEF, 4'h0, 10'd3, 16'h001F));   // R3, R4 top slot
        run_cmd(1, 1, mk(32'h11223344, 4'hF, 10'd5, 16'hBEE0));   // R1 keep all
        run_cmd(1, 1, mk(32'hAABBCCDD, 4'h5, 10'd63, 16'h0123));  // R1, R6 last core
        run_cmd(0, 1, mk(32'h55667788, 4'hA, 10'd0, 16'hFFE3));   // R4 masking
        run_cmd(1, 1, mk(32'h0, 4'h1, 10'd64, 16'h0040));         // R7 boundary
        run_cmd(1, 1, mk(32'h0, 4'h0, 10'd1023, 16'h0040));       // R7 top
        run_cmd(1, 0, mk(32'h12345678, 4'h3, 10'd2, 16'h0044));   // R8
        // Random mix.
        for (int n = 0; n < 200; n++) begin
            logic [63:0] w;
            logic [9:0]  c;
            w = {$urandom, $urandom};
            c = ($urandom % 2) ? 10'($urandom % MAXC) : 10'($urandom);
            w[25:16] = c;
            run_cmd(1'($urandom), ($urandom % 8) != 0, w);
        end
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog act=hung exp=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule